// File: doc/BRIEF.md
# Seven-to-one pixel lane serializer

This block takes one wide parallel pixel word per pixel clock and sends it out as a group of narrow serial lanes. With the default parameters, a 28-bit word is split into four groups of seven bits. Each group is shifted out on its own lane, one bit per bit-clock cycle. A fifth lane carries a frame clock that marks the seven-slot frame boundaries in step with the data. The bit clock runs at exactly seven times the pixel clock and is supplied from outside, because no frequency multiplier is built in.

The word can be captured on either edge of the pixel clock, chosen by a strobe-select input. Captured words cross into the bit-clock domain through a two-entry holding buffer with Gray-coded pointers. A word is moved into the shift registers only at a frame boundary. An active-low power-down input blanks every lane and drops the output enable, which a pad ring would use to float the drivers. After power-down is released, the outputs stay blank until the first complete word is ready. Transmission then starts on a frame boundary.

Top module: `pxl_link_tx`

## Requirements
- R1: When `edge_rise` is 1, the word on `pix_word` at each rising edge of `pix_clk` is transmitted, in capture order.
- R2: When `edge_rise` is 0, the word on `pix_word` at each falling edge of `pix_clk` is transmitted, in capture order.
- R3: Lane k (bit k of `lane_data`) carries word bits 7k..7k+6. Within a frame, slot s (s = 0..6) carries bit 7k+s, so the lowest bit goes first.
- R4: While `lane_oe` is 1, `clk_lane` is 1 in slots 0 to 3 and 0 in slots 4 to 6 of every frame. High runs last 4 bit clocks and low runs last 3.
- R5: While the block is powered up, every captured word is sent exactly once, with no loss, duplication or gap. `lane_oe` never drops between frames while words keep arriving.
- R6: After a bit-clock edge that samples `pd_n` = 0, `lane_oe`, `clk_lane` and all `lane_data` bits are 0. Words captured before or during power-down are discarded.
- R7: After power-down is released, `lane_oe` stays 0 and the lanes stay 0 until a word is ready. `lane_oe` then rises together with `clk_lane` = 1, which marks slot 0.
- R8: After a bit-clock edge that samples `rst_n` = 0, `lane_oe`, `clk_lane` and `lane_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock, seven times the pixel rate |
| pix_clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| pd_n | input | 1 | Active-low power-down |
| edge_rise | input | 1 | Capture-edge select: 1 selects the rising edge, 0 the falling edge |
| pix_word | input | 28 | Parallel pixel word |
| lane_data | output | 4 | Serial data lanes, one bit each |
| clk_lane | output | 1 | Frame clock lane |
| lane_oe | output | 1 | Lane output enable; 0 means the drivers are disabled |

## Verification
The bench uses the default parameters: four lanes of seven slots and a four-slot clock high time. It builds the pixel clock at exactly one seventh of the 125 MHz bit clock, offset by a fraction of a bit period. Every capture edge therefore falls between bit-clock edges, and a word that crosses domains can arrive at any slot phase of the frame. The data changes twice per pixel clock, so rising-edge and falling-edge capture pick up different word streams. Power-down is also applied in the middle of a frame, which exercises the discard and restart paths.

// File: rtl/pxl_link_pkg.sv
// Shared constants and helpers for the pixel lane serializer.
package pxl_link_pkg;
    localparam int DEF_LANES    = 4;   // serial data lanes
    localparam int DEF_SLOTS    = 7;   // bit slots per pixel clock
    localparam int DEF_CLK_HIGH = 4;   // frame-clock high slots

    // Binary to Gray code for the two-bit crossing pointers.
    function automatic logic [1:0] bin2gray(input logic [1:0] b);
        return b ^ (b >> 1);
    endfunction
endpackage

// File: rtl/pxl_capture.sv
// Pixel-domain capture. Samples the word on the selected pixel-clock edge
// and writes it into a two-entry holding buffer.
// Assumes edge_rise is static while pd_n is high. Falling-edge words are
// written into the buffer at the following rising edge.
module pxl_capture #(
    parameter int WORD_W = 28
) (
    input  logic                   pix_clk,
    input  logic                   rst_n,
    input  logic                   pd_n,
    input  logic                   edge_rise,
    input  logic [WORD_W-1:0]      din,
    output logic [1:0][WORD_W-1:0] hold_q,
    output logic [1:0]             wr_gray
);
    import pxl_link_pkg::*;

    logic [WORD_W-1:0] fall_word;
    logic              fall_vld;
    logic [1:0]        wr_bin;
    logic              wr_en;
    logic [WORD_W-1:0] wr_data;

    // Falling-edge sample, valid only while powered up.
    always_ff @(negedge pix_clk) begin
        if (!rst_n || !pd_n) begin
            fall_vld  <= 1'b0;
            fall_word <= '0;
        end else begin
            fall_vld  <= 1'b1;
            fall_word <= din;
        end
    end

    assign wr_en   = pd_n && (edge_rise || fall_vld);
    assign wr_data = edge_rise ? din : fall_word;

    // Write pointer, both as a binary count and as registered Gray code.
    always_ff @(posedge pix_clk) begin
        if (!rst_n || !pd_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else if (wr_en) begin
            wr_bin  <= wr_bin + 2'd1;
            wr_gray <= bin2gray(wr_bin + 2'd1);
        end
    end

    // Holding storage; the contents need no reset.
    always_ff @(posedge pix_clk) begin
        if (wr_en) hold_q[wr_bin[0]] <= wr_data;
    end
endmodule

// File: rtl/pxl_frame_seq.sv
// Bit-domain frame sequencer. Synchronises the write pointer, counts
// slots, loads a word at each frame boundary when one is ready, and
// drives the output enable and the frame-clock lane.
// Assumes bit_clk is exactly SLOTS times the pixel clock.
module pxl_frame_seq #(
    parameter int SLOTS    = 7,
    parameter int CLK_HIGH = 4
) (
    input  logic       bit_clk,
    input  logic       rst_n,
    input  logic       pd_n,
    input  logic [1:0] wr_gray,
    output logic       load,
    output logic       clear,
    output logic       rd_sel,
    output logic       lane_oe,
    output logic       clk_lane
);
    import pxl_link_pkg::*;

    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot;
    logic [1:0]        ws1, ws2;
    logic [1:0]        rd_bin;
    logic              at_end, avail;

    assign at_end = (slot == LAST);
    assign avail  = (ws2 != bin2gray(rd_bin));
    assign load   = at_end && avail;
    assign clear  = at_end && !avail;
    assign rd_sel = rd_bin[0];

    // Two-flop synchroniser for the write pointer.
    always_ff @(posedge bit_clk) begin
        if (!rst_n || !pd_n) begin
            ws1 <= '0;
            ws2 <= '0;
        end else begin
            ws1 <= wr_gray;
            ws2 <= ws1;
        end
    end

    // Slot counter, wraps after SLOTS cycles.
    always_ff @(posedge bit_clk) begin
        if (!rst_n || !pd_n) slot <= '0;
        else                 slot <= at_end ? '0 : slot + 1'b1;
    end

    // Read pointer, advanced when a frame is loaded.
    always_ff @(posedge bit_clk) begin
        if (!rst_n || !pd_n) rd_bin <= '0;
        else if (load)       rd_bin <= rd_bin + 2'd1;
    end

    // Output enable and frame clock, updated at the boundary and per slot.
    always_ff @(posedge bit_clk) begin
        if (!rst_n || !pd_n) begin
            lane_oe  <= 1'b0;
            clk_lane <= 1'b0;
        end else if (at_end) begin
            lane_oe  <= avail;
            clk_lane <= avail;
        end else begin
            clk_lane <= lane_oe && ((int'(slot) + 1) < CLK_HIGH);
        end
    end
endmodule

// File: rtl/pxl_lane_ser.sv
// One serial lane: loads a group of bits in parallel and shifts it out
// lowest bit first. Clears to zero when no word is available.
module pxl_lane_ser #(
    parameter int SLOTS = 7
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             load,
    input  logic             clear,
    input  logic [SLOTS-1:0] par_in,
    output logic             ser_out
);
    logic [SLOTS-1:0] sr;

    // Shift register, loaded at a boundary and shifted otherwise.
    always_ff @(posedge bit_clk) begin
        if (!rst_n || !pd_n || clear) sr <= '0;
        else if (load)                sr <= par_in;
        else                          sr <= sr >> 1;
    end

    assign ser_out = sr[0];
endmodule

// File: rtl/pxl_link_tx.sv
// Top level of the pixel lane serializer: capture, domain crossing,
// frame sequencing and one shift register per lane.
// Assumes bit_clk runs at exactly SLOTS times pix_clk.
module pxl_link_tx #(
    parameter int LANES    = pxl_link_pkg::DEF_LANES,
    parameter int SLOTS    = pxl_link_pkg::DEF_SLOTS,
    parameter int CLK_HIGH = pxl_link_pkg::DEF_CLK_HIGH,
    localparam int WORD_W  = LANES * SLOTS
) (
    input  logic              bit_clk,
    input  logic              pix_clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              edge_rise,
    input  logic [WORD_W-1:0] pix_word,
    output logic [LANES-1:0]  lane_data,
    output logic              clk_lane,
    output logic              lane_oe
);
    logic [1:0][WORD_W-1:0] hold_q;
    logic [1:0]             wr_gray;
    logic                   load, clear, rd_sel;
    logic [WORD_W-1:0]      rd_word;

    pxl_capture #(.WORD_W(WORD_W)) u_cap (
        .pix_clk  (pix_clk),
        .rst_n    (rst_n),
        .pd_n     (pd_n),
        .edge_rise(edge_rise),
        .din      (pix_word),
        .hold_q   (hold_q),
        .wr_gray  (wr_gray)
    );

    pxl_frame_seq #(.SLOTS(SLOTS), .CLK_HIGH(CLK_HIGH)) u_seq (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .wr_gray (wr_gray),
        .load    (load),
        .clear   (clear),
        .rd_sel  (rd_sel),
        .lane_oe (lane_oe),
        .clk_lane(clk_lane)
    );

    assign rd_word = hold_q[rd_sel];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        pxl_lane_ser #(.SLOTS(SLOTS)) u_ser (
            .bit_clk(bit_clk),
            .rst_n  (rst_n),
            .pd_n   (pd_n),
            .load   (load),
            .clear  (clear),
            .par_in (rd_word[l*SLOTS +: SLOTS]),
            .ser_out(lane_data[l])
        );
    end
endmodule

// File: rtl/pxl_link_tx_chk.sv
// Protocol checker for the lane serializer, attached by bind.
// Tracks how long the frame clock stays high and low while enabled.
module pxl_link_tx_chk #(
    parameter int LANES    = 4,
    parameter int SLOTS    = 7,
    parameter int CLK_HIGH = 4
) (
    input logic             bit_clk,
    input logic             rst_n,
    input logic             pd_n,
    input logic [LANES-1:0] lane_data,
    input logic             clk_lane,
    input logic             lane_oe
);
    logic [7:0] hi_run, lo_run;

    // Run-length counters for the enabled frame clock.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= (lane_oe && clk_lane)  ? hi_run + 8'd1 : 8'd0;
            lo_run <= (lane_oe && !clk_lane) ? lo_run + 8'd1 : 8'd0;
        end
    end

    // R8: reset blanks the outputs
    a_r8_reset_blank: assert property (@(posedge bit_clk)
        !rst_n |=> (!lane_oe && !clk_lane && lane_data == '0));

    // R6: power-down blanks every lane
    a_r6_pd_blank: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !pd_n |=> (!lane_oe && !clk_lane && lane_data == '0));

    // R7: transmission starts at slot 0
    a_r7_start_slot0: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(lane_oe) |-> clk_lane);

    // R4: high part of the frame clock lasts CLK_HIGH slots
    a_r4_high_run: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (lane_oe && $past(lane_oe) && $fell(clk_lane)) |-> (hi_run == 8'(CLK_HIGH)));

    // R4: low part lasts the remaining slots
    a_r4_low_run: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (lane_oe && $past(lane_oe) && $rose(clk_lane)) |-> (lo_run == 8'(SLOTS - CLK_HIGH)));

    // R7: disabled lanes carry no data
    a_r7_quiet_when_off: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !lane_oe |-> (lane_data == '0 && !clk_lane));
endmodule

bind pxl_link_tx pxl_link_tx_chk #(.LANES(LANES), .SLOTS(SLOTS), .CLK_HIGH(CLK_HIGH)) u_chk (
    .bit_clk  (bit_clk),
    .rst_n    (rst_n),
    .pd_n     (pd_n),
    .lane_data(lane_data),
    .clk_lane (clk_lane),
    .lane_oe  (lane_oe)
);

// File: tb/pxl_link_tx_test.sv
// Bench: behavioural reference, a queue of captured words plus a slot
// index, compared with the lanes on every bit clock.
module pxl_link_tx_test;
    localparam int LANES  = 4;
    localparam int SLOTS  = 7;
    localparam int WORD_W = LANES * SLOTS;

    logic              bit_clk = 1'b0;
    logic              pix_clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pd_n = 1'b0;
    logic              edge_rise = 1'b1;
    logic [WORD_W-1:0] pix_word = '0;
    logic [LANES-1:0]  lane_data;
    logic              clk_lane, lane_oe;

    int checks = 0;
    int fails  = 0;
    logic [WORD_W-1:0] q[$];
    int frames = 0;
    bit finished = 0;

    pxl_link_tx uut (
        .bit_clk(bit_clk), .pix_clk(pix_clk), .rst_n(rst_n), .pd_n(pd_n),
        .edge_rise(edge_rise), .pix_word(pix_word),
        .lane_data(lane_data), .clk_lane(clk_lane), .lane_oe(lane_oe)
    );

    // 125 MHz bit clock; pixel clock at one seventh, offset by 2 ns.
    always #4 bit_clk = ~bit_clk;
    initial begin
        #2;
        forever begin pix_clk = ~pix_clk; #28; end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Stimulus: a new word twice per pixel period, away from both edges.
    initial begin
        int n = 0;
        logic [31:0] lcg = 32'h1234_5678;
        #16;
        forever begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            if (n % 9 == 0)      pix_word = '1;
            else if (n % 9 == 1) pix_word = WORD_W'(1) << (n % WORD_W);
            else                 pix_word = lcg[WORD_W-1:0] ^ WORD_W'(n);
            n++;
            #28;
        end
    end

    // Reference capture (R1, R2).
    always @(posedge pix_clk) if (rst_n && pd_n && edge_rise)  q.push_back(pix_word);
    always @(negedge pix_clk) if (rst_n && pd_n && !edge_rise) q.push_back(pix_word);

    logic pd_at_edge = 1'b0;
    logic rst_at_edge = 1'b0;
    always @(posedge bit_clk) begin
        pd_at_edge  = pd_n;
        rst_at_edge = rst_n;
    end

    // Per-clock comparison against the reference.
    int m = 0;
    bit prev_oe = 0;
    logic [WORD_W-1:0] acc = '0;
    always @(negedge bit_clk) begin
        if (!finished && rst_at_edge) begin
            if (!pd_at_edge) begin
                check(!lane_oe && !clk_lane && lane_data == '0, "R6 blank in power-down",
                      {lane_oe, clk_lane, lane_data}, 0);
                prev_oe = 0;
            end else if (lane_oe) begin
                if (!prev_oe) begin
                    check(clk_lane == 1'b1, "R7 start at slot 0", clk_lane, 1);
                    m = 0;
                end
                check(clk_lane == (m < 4), "R4 frame clock pattern", clk_lane, (m < 4));
                for (int k = 0; k < LANES; k++) acc[k*SLOTS + m] = lane_data[k];
                if (m == SLOTS - 1) begin
                    frames++;
                    if (q.size() == 0) check(0, "R5 word sent without capture", acc, 0);
                    else begin
                        logic [WORD_W-1:0] e;
                        e = q.pop_front();
                        check(acc == e, edge_rise ? "R1 R3 word" : "R2 R3 word", acc, e);
                    end
                    m = 0;
                end else m++;
                prev_oe = 1;
            end else begin
                if (prev_oe) check(0, "R5 enable dropped while running", 0, 1);
                check(!clk_lane && lane_data == '0, "R7 quiet before start",
                      {clk_lane, lane_data}, 0);
                prev_oe = 0;
            end
        end
    end

    task automatic power(input bit on);
        @(negedge bit_clk);
        #3;
        pd_n = on;
        if (!on) q.delete();
    endtask

    task automatic run_phase(input int pix_cycles, input string req);
        int f0;
        f0 = frames;
        repeat (pix_cycles * SLOTS) @(posedge bit_clk);
        check(frames - f0 >= pix_cycles - 6, {req, " frame throughput"}, frames - f0, pix_cycles - 6);
        check(q.size() <= 3, "R5 no backlog", q.size(), 3);
    endtask

    // Watchdog.
    initial begin
        #1_000_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (40) @(posedge bit_clk);
        #1;
        check(!lane_oe && !clk_lane && lane_data == '0, "R8 reset state", {lane_oe, clk_lane, lane_data}, 0);
        @(negedge bit_clk); #3; rst_n = 1'b1;
        repeat (30) @(posedge bit_clk);
        #1;
        check(!lane_oe, "R6 still powered down", lane_oe, 0);

        edge_rise = 1'b1;
        power(1);
        run_phase(30, "R1");

        // Power-down in the middle of a frame, then falling-edge capture.
        repeat (3) @(posedge bit_clk);
        power(0);
        repeat (25) @(posedge bit_clk);
        edge_rise = 1'b0;
        power(1);
        run_phase(30, "R2");

        power(0);
        repeat (30) @(posedge bit_clk);
        edge_rise = 1'b1;
        power(1);
        run_phase(20, "R1");

        power(0);
        repeat (10) @(posedge bit_clk);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule